// File: doc/BRIEF.md
# Pixel Point Operation Unit

This block sits in front of an image filter's line storage and applies one point operation to every 8-bit pixel of a raster stream. Operand A is the incoming pixel, registered on entry. Operand B is held in an 8-bit operand register. That register loads from a coefficient bus on any clock edge where its load enable is high, so a constant threshold, mask or offset can be set up once and reused for many pixels.

A 10-bit microcode word, written through the shared configuration port, selects the function. Its low seven bits pick an arithmetic, logical or constant function. Its top three bits pick a shift of up to three places left or right. The shift is applied to the function's result, whatever that function is. The registered, shifted result is passed on to the line storage.

Top module: `pix_point_alu`

## Requirements
- R1: While rst_ni is low, result_o, the pixel register and the operand B register are 0, and the microcode is 10'h018 (function pass A, no shift).
- R2: A pixel presented on pix_i at a rising clock edge gives its result on result_o after the following rising edge, a two-edge latency.
- R3: The operand B register takes opnd_i on a rising edge when opnd_ld_i is high. When opnd_ld_i is low, it keeps its value.
- R4: When ucode_we_i is high at a rising edge, ucode_i is stored. The new microcode governs the results registered from the next edge onward. Bits 9:7 form the shift field and bits 6:0 form the function field.
- R5: Constant function codes: 7'h00 gives 8'h00 and 7'h01 gives 8'hFF, independent of both operands.
- R6: Pass and invert codes: 7'h18 gives A, 7'h02 gives B, 7'h03 gives ~A, and 7'h04 gives ~B.
- R7: Arithmetic codes wrap modulo 256: 7'h05 gives A+B, 7'h06 gives A-B, and 7'h07 gives B-A.
- R8: AND/OR codes: 7'h08 gives A&B, 7'h09 gives ~A&B, 7'h0A gives A&~B, 7'h0B gives A|B, 7'h0C gives ~A|B, and 7'h0D gives A|~B.
- R9: Two-operand logical codes: 7'h0E gives NAND, 7'h0F gives NOR, 7'h10 gives XOR, and 7'h11 gives XNOR.
- R10: Shift field codes 3'b001, 3'b010 and 3'b011 shift the function result right by 1, 2 and 3 places, filling with zeros.
- R11: Shift field codes 3'b100, 3'b101 and 3'b110 shift the function result left by 1, 2 and 3 places. Bits moved past bit 7 are lost, and zeros fill from the bottom.
- R12: Shift field code 3'b111 acts as no shift. Any function code not listed in R5 to R9 acts as pass A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Pixel stream input, operand A |
| opnd_i | input | 8 | Coefficient bus value for operand B |
| opnd_ld_i | input | 1 | Load enable for the operand B register |
| ucode_we_i | input | 1 | Microcode write strobe from the configuration port |
| ucode_i | input | 10 | Microcode write data |
| result_o | output | 8 | Registered, shifted point-operation result |

## Verification
The assertions check the following on every cycle:
- the operand B register loads and holds as R3 describes;
- a microcode write takes effect;
- pass A with no shift reproduces the registered pixel one edge later;
- the zero constant yields zero;
- the zero fill of the largest right and left shifts.

Only the directed scenarios can show:
- the exact value of each function code;
- wrap-around in add and subtract;
- the inverted-operand variants;
- the fall-back of unlisted codes to pass A and of shift code 111 to no shift.

These scenarios compare the result against values worked out from the requirements.

// File: rtl/pix_point_alu_pkg.sv
package pix_point_alu_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned OPW   = 7;
  localparam int unsigned SHW   = 3;
  localparam int unsigned UCW   = OPW + SHW;

  localparam logic [OPW-1:0] OP_ZERO   = 7'h00;
  localparam logic [OPW-1:0] OP_ONES   = 7'h01;
  localparam logic [OPW-1:0] OP_B      = 7'h02;
  localparam logic [OPW-1:0] OP_NA     = 7'h03;
  localparam logic [OPW-1:0] OP_NB     = 7'h04;
  localparam logic [OPW-1:0] OP_ADD    = 7'h05;
  localparam logic [OPW-1:0] OP_SUB_AB = 7'h06;
  localparam logic [OPW-1:0] OP_SUB_BA = 7'h07;
  localparam logic [OPW-1:0] OP_AND    = 7'h08;
  localparam logic [OPW-1:0] OP_AND_NA = 7'h09;
  localparam logic [OPW-1:0] OP_AND_NB = 7'h0A;
  localparam logic [OPW-1:0] OP_OR     = 7'h0B;
  localparam logic [OPW-1:0] OP_OR_NA  = 7'h0C;
  localparam logic [OPW-1:0] OP_OR_NB  = 7'h0D;
  localparam logic [OPW-1:0] OP_NAND   = 7'h0E;
  localparam logic [OPW-1:0] OP_NOR    = 7'h0F;
  localparam logic [OPW-1:0] OP_XOR    = 7'h10;
  localparam logic [OPW-1:0] OP_XNOR   = 7'h11;
  localparam logic [OPW-1:0] OP_A      = 7'h18;

  localparam logic [UCW-1:0] UCODE_RST = {3'b000, OP_A};

  typedef struct packed {
    logic [SHW-1:0] shift;
    logic [OPW-1:0] op;
  } ucode_t;
endpackage

// File: rtl/pix_point_alu_ucode.sv
module pix_point_alu_ucode
  import pix_point_alu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [UCW-1:0] data_i,
  output ucode_t         ucode_o
);
  ucode_t ucode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ucode_q <= ucode_t'(UCODE_RST);
    else if (we_i) ucode_q <= ucode_t'(data_i);
  end

  assign ucode_o = ucode_q;

  p_ucode_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ucode_q == ucode_t'($past(data_i))));

  p_ucode_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ucode_q));
endmodule

// File: rtl/pix_point_alu_func.sv
module pix_point_alu_func
  import pix_point_alu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic [DW-1:0]  y_o
);
  always_comb begin
    unique case (op_i)
      OP_ZERO:   y_o = '0;
      OP_ONES:   y_o = '1;
      OP_B:      y_o = b_i;
      OP_NA:     y_o = ~a_i;
      OP_NB:     y_o = ~b_i;
      OP_ADD:    y_o = a_i + b_i;
      OP_SUB_AB: y_o = a_i - b_i;
      OP_SUB_BA: y_o = b_i - a_i;
      OP_AND:    y_o = a_i & b_i;
      OP_AND_NA: y_o = ~a_i & b_i;
      OP_AND_NB: y_o = a_i & ~b_i;
      OP_OR:     y_o = a_i | b_i;
      OP_OR_NA:  y_o = ~a_i | b_i;
      OP_OR_NB:  y_o = a_i | ~b_i;
      OP_NAND:   y_o = ~(a_i & b_i);
      OP_NOR:    y_o = ~(a_i | b_i);
      OP_XOR:    y_o = a_i ^ b_i;
      OP_XNOR:   y_o = ~(a_i ^ b_i);
      default:   y_o = a_i; // OP_A and all unlisted codes
    endcase
  end
endmodule

// File: rtl/pix_point_alu_shift.sv
module pix_point_alu_shift
  import pix_point_alu_pkg::*;
#(
  parameter int unsigned W    = DW,
  parameter int unsigned MAXS = 3
) (
  input  logic [SHW-1:0] code_i,
  input  logic [W-1:0]   d_i,
  output logic [W-1:0]   q_o
);
  localparam int unsigned NS = MAXS + 1;

  logic [W-1:0] rsh [NS];
  logic [W-1:0] lsh [NS];

  for (genvar s = 0; s < NS; s++) begin : g_amt
    assign rsh[s] = d_i >> s;
    assign lsh[s] = d_i << s;
  end

  // code[2] picks direction, code[1:0] the distance; 111 is no shift
  always_comb begin
    if (code_i == '1)     q_o = d_i;
    else if (code_i[2])   q_o = lsh[code_i[1:0] + 2'd1];
    else                  q_o = rsh[code_i[1:0]];
  end
endmodule

// File: rtl/pix_point_alu.sv
module pix_point_alu
  import pix_point_alu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  pix_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic           opnd_ld_i,
  input  logic           ucode_we_i,
  input  logic [UCW-1:0] ucode_i,
  output logic [DW-1:0]  result_o
);
  logic [DW-1:0] a_q, b_q, f_y, s_y, res_q;
  ucode_t        uc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      a_q   <= pix_i;
      res_q <= s_y;
      if (opnd_ld_i) b_q <= opnd_i;
    end
  end

  pix_point_alu_ucode u_ucode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ucode_we_i),
    .data_i  (ucode_i),
    .ucode_o (uc)
  );

  pix_point_alu_func u_func (
    .op_i (uc.op),
    .a_i  (a_q),
    .b_i  (b_q),
    .y_o  (f_y)
  );

  pix_point_alu_shift #(.W(DW), .MAXS(3)) u_shift (
    .code_i (uc.shift),
    .d_i    (f_y),
    .q_o    (s_y)
  );

  assign result_o = res_q;

  p_b_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_ld_i |=> (b_q == $past(opnd_i)));

  p_b_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opnd_ld_i |=> $stable(b_q));

  p_pass_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uc.op == OP_A && uc.shift == 3'b000) |=> (result_o == $past(a_q)));

  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uc.op == OP_ZERO) |=> (result_o == '0));

  p_rsh_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uc.shift == 3'b011) |=> (result_o[DW-1:DW-3] == 3'b000));

  p_lsh_fill_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uc.shift == 3'b110) |=> (result_o[2:0] == 3'b000));
endmodule

// File: tb/pix_point_alu_tb_top.sv
module pix_point_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pix = '0, opnd = '0;
  logic       opnd_ld = 1'b0, uc_we = 1'b0;
  logic [9:0] uc_d = '0;
  logic [7:0] res;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_point_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .opnd_i(opnd),
    .opnd_ld_i(opnd_ld), .ucode_we_i(uc_we), .ucode_i(uc_d), .result_o(res)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic set_uc(input logic [2:0] sh, input logic [6:0] op);
    @(negedge clk); uc_we = 1'b1; uc_d = {sh, op};
    @(negedge clk); uc_we = 1'b0; uc_d = '1;
  endtask

  task automatic set_b(input logic [7:0] v);
    @(negedge clk); opnd_ld = 1'b1; opnd = v;
    @(negedge clk); opnd_ld = 1'b0; opnd = ~v;
  endtask

  task automatic run(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); pix = a;
    @(negedge clk);
    @(negedge clk);
    chk(req, res, exp);
  endtask

  task automatic t_reset;
    chk("R1 reset result", res, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    run("R1 default pass A", 8'h3C, 8'h3C);
  endtask

  task automatic t_latency;
    @(negedge clk); pix = 8'h11;
    @(negedge clk); pix = 8'h22;
    chk("R2 one edge not yet", res === 8'h11 ? 8'h00 : res, res);
    @(negedge clk); pix = 8'h33;
    chk("R2 first result", res, 8'h11);
    @(negedge clk);
    chk("R2 second result", res, 8'h22);
  endtask

  task automatic t_opnd;
    set_b(8'h55);
    set_uc(3'b000, 7'h02);
    run("R3 B loaded", 8'h00, 8'h55);
    @(negedge clk); opnd_ld = 1'b0; opnd = 8'hAA;
    run("R3 B held", 8'h00, 8'h55);
    opnd = 8'h00;
  endtask

  task automatic t_funcs;
    logic [7:0] a = 8'hC3, b = 8'h5A;
    set_b(b);
    set_uc(3'b000, 7'h00); run("R5 zero", a, 8'h00);
    set_uc(3'b000, 7'h01); run("R5 ones", a, 8'hFF);
    set_uc(3'b000, 7'h18); run("R6 A", a, a);
    set_uc(3'b000, 7'h02); run("R6 B", a, b);
    set_uc(3'b000, 7'h03); run("R6 notA", a, ~a);
    set_uc(3'b000, 7'h04); run("R6 notB", a, ~b);
    set_uc(3'b000, 7'h05); run("R7 add wrap", a, 8'h1D);
    set_uc(3'b000, 7'h06); run("R7 A-B", a, 8'h69);
    set_uc(3'b000, 7'h07); run("R7 B-A wrap", a, 8'h97);
    set_uc(3'b000, 7'h08); run("R8 and", a, a & b);
    set_uc(3'b000, 7'h09); run("R8 nA and B", a, ~a & b);
    set_uc(3'b000, 7'h0A); run("R8 A and nB", a, a & ~b);
    set_uc(3'b000, 7'h0B); run("R8 or", a, a | b);
    set_uc(3'b000, 7'h0C); run("R8 nA or B", a, ~a | b);
    set_uc(3'b000, 7'h0D); run("R8 A or nB", a, a | ~b);
    set_uc(3'b000, 7'h0E); run("R9 nand", a, ~(a & b));
    set_uc(3'b000, 7'h0F); run("R9 nor", a, ~(a | b));
    set_uc(3'b000, 7'h10); run("R9 xor", a, a ^ b);
    set_uc(3'b000, 7'h11); run("R9 xnor", a, ~(a ^ b));
  endtask

  task automatic t_shift;
    set_uc(3'b001, 7'h18); run("R10 right 1", 8'hF1, 8'h78);
    set_uc(3'b010, 7'h18); run("R10 right 2", 8'hF1, 8'h3C);
    set_uc(3'b011, 7'h18); run("R10 right 3", 8'hFF, 8'h1F);
    set_uc(3'b100, 7'h18); run("R11 left 1", 8'h8F, 8'h1E);
    set_uc(3'b101, 7'h18); run("R11 left 2", 8'h8F, 8'h3C);
    set_uc(3'b110, 7'h18); run("R11 left 3", 8'hFF, 8'hF8);
    set_b(8'h01);
    set_uc(3'b100, 7'h05); run("R4 R11 shift after add", 8'h80, 8'h02);
  endtask

  task automatic t_fallback;
    set_uc(3'b111, 7'h18); run("R12 shift 111", 8'hA5, 8'hA5);
    set_uc(3'b000, 7'h55); run("R12 unlisted op", 8'h6E, 8'h6E);
    set_uc(3'b000, 7'h7F); run("R12 op 7F", 8'h09, 8'h09);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset;
    t_latency;
    t_opnd;
    t_funcs;
    t_shift;
    t_fallback;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule